// File: doc/BRIEF.md
# Video Register Command Stream Decoder

This block takes a byte-wide stream of register-write commands and keeps a bank of 8-bit video control registers up to date. A byte is taken on every clock edge where `in_valid` is high. A write command is four bytes long: a header byte 0xAF, an operation byte 0x20, the register address, and the data value. Any other framing raises a one-cycle error pulse, and the decoder then searches the stream for the next header byte.

Each register has two copies. The shadow copy takes every write. The active copy drives the display timing. A control address lets the host freeze the active bank and stage a whole new mode in the shadow bank. A single unlock command then copies every staged value into the active bank on one clock edge, so the timing logic never sees a mix of old and new settings. The block also puts together a few fields from the active bank: two 24-bit frame-base pointers, a 16-bit pixel-clock divider stored in the reverse byte order, and the sync/power state.

Top module: `vidreg_cmd_decoder`

## Requirements
- R1: After reset the bank is unlocked and `err` is low. Every register in both banks reads 0x00, except address 0x1F, which reads 0x07 in both banks.
- R2: The byte sequence 0xAF, 0x20, A, D writes D to register A. A byte is taken only on an edge with `in_valid` high, and idle cycles may fall between the bytes. The new value is visible in the cycle after the edge that takes D.
- R3: When a command should start and the byte is not 0xAF, `err` goes high for one cycle. After that, bytes other than 0xAF are dropped with no further error until an 0xAF arrives.
- R4: When the byte after 0xAF is not 0x20, `err` goes high for one cycle. If that byte is itself 0xAF, it is taken as the header of a new command. Otherwise the decoder searches for 0xAF as in R3.
- R5: Writing 0x00 to address 0xFF sets `locked`. While locked, writes change only the shadow bank and the active bank holds its value.
- R6: Writing 0xFF to address 0xFF clears `locked` and copies the whole shadow bank into the active bank in the same cycle.
- R7: While unlocked, a write updates the same register in both banks at once.
- R8: A write to an address at or above NREG, other than 0xFF, changes nothing. A write to 0xFF with a data value other than 0x00 or 0xFF changes nothing.
- R9: `base16` is {reg 0x20, reg 0x21, reg 0x22} and `base8` is {reg 0x26, reg 0x27, reg 0x28}. Both are taken from the active bank, with the most significant byte at the lowest address.
- R10: `pclk_div` is {reg 0x1C, reg 0x1B} from the active bank, so the low byte sits at the lower address.
- R11: All three outputs are taken from the active bank. `sync_en` is high when reg 0x1F is 0x00. `pwr_down` is high when reg 0x1F is 0x07. `depth24` is bit 0 of reg 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_byte | input | 8 | Command stream byte |
| err | output | 1 | One-cycle pulse on a framing error |
| locked | output | 1 | Active bank is frozen |
| shadow_bank | output | NREG*8 | Staged registers, register n at bits [8n+7:8n] |
| active_bank | output | NREG*8 | Committed registers, same layout |
| sync_en | output | 1 | Horizontal and vertical sync enabled |
| pwr_down | output | 1 | Sync control in power-down |
| depth24 | output | 1 | 8bpp plane added for 24-bit colour |
| base16 | output | 24 | 16bpp plane base pointer |
| base8 | output | 24 | 8bpp plane base pointer |
| pclk_div | output | 16 | Pixel-clock setting |

## Verification
A framing state that is out of step shows up one cycle after the offending byte. Either `err` pulses when it should stay quiet, or a later well-formed command lands on the wrong register, and the next bank comparison reveals that. A broken lock or commit path shows as active and shadow banks that differ while unlocked, or as an active bank that moves during a locked period. Both are visible in the cycle after the write that exposes them. Byte-order mistakes in the assembled fields show on `base16`, `base8` and `pclk_div` as soon as the value has been committed.

// File: rtl/vidreg_cmd_decoder.sv
module vidreg_cmd_decoder #(
  parameter int NREG = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              err,
  output logic              locked,
  output logic [NREG*8-1:0] shadow_bank,
  output logic [NREG*8-1:0] active_bank,
  output logic              sync_en,
  output logic              pwr_down,
  output logic              depth24,
  output logic [23:0]       base16,
  output logic [23:0]       base8,
  output logic [15:0]       pclk_div
);
  localparam logic [7:0] HDR     = 8'hAF;
  localparam logic [7:0] OP_WR   = 8'h20;
  localparam logic [7:0] A_CTL   = 8'hFF;
  localparam int         A_SYNC  = 'h1F;
  localparam int         A_DEPTH = 'h00;
  localparam int         A_B16   = 'h20;
  localparam int         A_B8    = 'h26;
  localparam int         A_PCLK  = 'h1B;

  typedef enum logic [2:0] {S_IDLE, S_HUNT, S_OP, S_ADDR, S_DATA} st_t;

  st_t        st;
  logic [7:0] addr_q;
  logic       err_q, lock_q;

  wire wr_fire   = in_valid && (st == S_DATA);
  wire do_lock   = wr_fire && (addr_q == A_CTL) && (in_byte == 8'h00);
  wire do_unlock = wr_fire && (addr_q == A_CTL) && (in_byte == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      err_q  <= 1'b0;
      addr_q <= 8'h00;
    end else begin
      err_q <= 1'b0;
      if (in_valid) begin
        case (st)
          S_IDLE: if (in_byte == HDR) st <= S_OP;
                  else begin st <= S_HUNT; err_q <= 1'b1; end
          S_HUNT: if (in_byte == HDR) st <= S_OP;
          S_OP:   if (in_byte == OP_WR) st <= S_ADDR;
                  else begin
                    err_q <= 1'b1;
                    st    <= (in_byte == HDR) ? S_OP : S_HUNT;
                  end
          S_ADDR: begin addr_q <= in_byte; st <= S_DATA; end
          S_DATA: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         lock_q <= 1'b0;
    else if (do_lock)   lock_q <= 1'b1;
    else if (do_unlock) lock_q <= 1'b0;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RVAL = (g == A_SYNC) ? 8'h07 : 8'h00;
    logic [7:0] sh_r, ac_r;
    wire hit = wr_fire && (addr_q == 8'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)   sh_r <= RVAL;
      else if (hit) sh_r <= in_byte;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                ac_r <= RVAL;
      else if (do_unlock)        ac_r <= sh_r;
      else if (hit && !lock_q)   ac_r <= in_byte;
    end

    assign shadow_bank[g*8 +: 8] = sh_r;
    assign active_bank[g*8 +: 8] = ac_r;
  end

  assign err      = err_q;
  assign locked   = lock_q;
  assign sync_en  = active_bank[A_SYNC*8 +: 8] == 8'h00;
  assign pwr_down = active_bank[A_SYNC*8 +: 8] == 8'h07;
  assign depth24  = active_bank[A_DEPTH*8];
  assign base16   = {active_bank[A_B16*8 +: 8], active_bank[(A_B16+1)*8 +: 8],
                     active_bank[(A_B16+2)*8 +: 8]};
  assign base8    = {active_bank[A_B8*8 +: 8], active_bank[(A_B8+1)*8 +: 8],
                     active_bank[(A_B8+2)*8 +: 8]};
  assign pclk_div = {active_bank[(A_PCLK+1)*8 +: 8], active_bank[A_PCLK*8 +: 8]};
endmodule

// File: rtl/vidreg_cmd_decoder_chk.sv
module vidreg_cmd_decoder_chk #(
  parameter int NREG = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              err,
  input logic              locked,
  input logic [NREG*8-1:0] shadow_bank,
  input logic [NREG*8-1:0] active_bank
);
  a_r7_unlocked_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> active_bank == shadow_bank);

  a_r5_locked_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(active_bank));

  a_r6_unlock_copies: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> active_bank == shadow_bank);

  a_r3_err_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid));

  a_r5_lock_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(in_valid));
endmodule

bind vidreg_cmd_decoder vidreg_cmd_decoder_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .err(err), .locked(locked),
  .shadow_bank(shadow_bank), .active_bank(active_bank)
);

// File: tb/sim_vidreg_cmd_decoder.sv
`timescale 1ns/1ps
module sim_vidreg_cmd_decoder;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic err, locked, sync_en, pwr_down, depth24;
  logic [N*8-1:0] shadow_bank, active_bank;
  logic [23:0] base16, base8;
  logic [15:0] pclk_div;

  vidreg_cmd_decoder #(.NREG(N)) u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit err_q[$];
  logic [7:0] m_sh [N];
  logic [7:0] m_act[N];
  bit m_lock = 0;
  int m_st = 0;
  logic [7:0] m_addr = 8'h00;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    summary();
  end

  task automatic chk(input string tag, input string nm,
                     input logic [N*8-1:0] act, input logic [N*8-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hFF) begin
      if (d == 8'h00) m_lock = 1;
      else if (d == 8'hFF) begin
        m_lock = 0;
        for (int i = 0; i < N; i++) m_act[i] = m_sh[i];
      end
    end else if (int'(a) < N) begin
      m_sh[a] = d;
      if (!m_lock) m_act[a] = d;
    end
  endtask

  task automatic put(input logic [7:0] b);
    bit e = 0;
    case (m_st)
      0: if (b == 8'hAF) m_st = 2; else begin e = 1; m_st = 1; end
      1: if (b == 8'hAF) m_st = 2;
      2: if (b == 8'h20) m_st = 3;
         else begin e = 1; m_st = (b == 8'hAF) ? 2 : 1; end
      3: begin m_addr = b; m_st = 4; end
      default: begin apply(m_addr, b); m_st = 0; end
    endcase
    err_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h5A;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input int gap);
    put(8'hAF); idle(gap);
    put(8'h20); idle(gap);
    put(a);     idle(gap);
    put(d);
  endtask

  task automatic check_state(input string tag);
    logic [N*8-1:0] es, ea;
    for (int i = 0; i < N; i++) begin
      es[i*8 +: 8] = m_sh[i];
      ea[i*8 +: 8] = m_act[i];
    end
    idle(1);
    chk(tag, "shadow_bank", shadow_bank, es);
    chk(tag, "active_bank", active_bank, ea);
    chk(tag, "locked", N'(locked), N'(m_lock));
    chk("R9", "base16", N'(base16), N'({m_act['h20], m_act['h21], m_act['h22]}));
    chk("R9", "base8", N'(base8), N'({m_act['h26], m_act['h27], m_act['h28]}));
    chk("R10", "pclk_div", N'(pclk_div), N'({m_act['h1C], m_act['h1B]}));
    chk("R11", "sync_en", N'(sync_en), N'(m_act['h1F] == 8'h00));
    chk("R11", "pwr_down", N'(pwr_down), N'(m_act['h1F] == 8'h07));
    chk("R11", "depth24", N'(depth24), N'(m_act[0][0]));
  endtask

  logic acc = 1'b0;
  always @(posedge clk) acc <= rst_n && in_valid;
  always @(negedge clk) begin
    if (acc) begin
      bit e;
      e = (err_q.size() > 0) ? err_q.pop_front() : 1'b0;
      n_chk++;
      if (err !== e) begin
        n_fail++;
        $display("FAIL R3/R4 err pulse actual=%b expected=%b", err, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_sh[i]  = (i == 'h1F) ? 8'h07 : 8'h00;
      m_act[i] = m_sh[i];
    end
    idle(3);
    rst_n = 1'b1;
    check_state("R1");
    chk("R1", "err", N'(err), '0);

    wr(8'h05, 8'h3C, 0);          check_state("R2");
    wr(8'h06, 8'hC3, 2);          check_state("R2");
    wr(8'h07, 8'h11, 0);          check_state("R7");

    wr(8'h20, 8'h12, 0); wr(8'h21, 8'h34, 1); wr(8'h22, 8'h56, 0);
    wr(8'h26, 8'h9A, 0); wr(8'h27, 8'hBC, 0); wr(8'h28, 8'hDE, 0);
    check_state("R9");
    wr(8'h1B, 8'h34, 0); wr(8'h1C, 8'h12, 0);
    check_state("R10");

    wr(8'h1F, 8'h00, 0); wr(8'h00, 8'h01, 0); check_state("R11");
    wr(8'h1F, 8'h01, 0); check_state("R11");
    wr(8'h1F, 8'h07, 0); check_state("R11");

    wr(8'hFF, 8'h00, 0);
    wr(8'h10, 8'hAA, 0); wr(8'h20, 8'hEE, 1); wr(8'h1F, 8'h00, 0);
    check_state("R5");
    wr(8'hFF, 8'hFF, 0);          check_state("R6");

    wr(8'h40, 8'h99, 0); wr(8'hFE, 8'h77, 0);
    check_state("R8");
    wr(8'hFF, 8'h55, 0);          check_state("R8");
    wr(8'hFF, 8'h00, 0); wr(8'hFF, 8'h33, 0);
    check_state("R8");
    wr(8'hFF, 8'hFF, 0);

    put(8'h11); put(8'h22); put(8'h20);
    wr(8'h03, 8'h77, 0);          check_state("R3");

    put(8'hAF); put(8'h21); put(8'h05); put(8'h06);
    wr(8'h08, 8'h44, 0);          check_state("R4");
    put(8'hAF); put(8'hAF); put(8'h20); put(8'h09); put(8'h66);
    check_state("R4");

    idle(3);
    chk("R2", "scoreboard drained", N'(err_q.size()), '0);
    summary();
  end
endmodule